// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a small 16-bit processor with a single accumulator. It holds a 12-bit program counter, a 16-bit instruction register and a 16-bit accumulator. One shared adder serves both the arithmetic and the program counter step. A controller with one state bit switches between a fetch cycle and an execute cycle. The core talks to a single-port word memory of 4096 locations. It issues an address, a request strobe and a read/not-write line. Write data and read data travel on separate ports. The memory must return read data within the cycle in which the address is issued, and it commits a write at the end of that cycle.

Each instruction word carries an operation in bits [15:12] and an operand address S in bits [11:0]. There are four operations that use a memory operand: load, store, add and subtract. Each of these spends one cycle on the operand access and one cycle on the fetch of the next instruction. There are three jumps: unconditional, taken when the accumulator sign is clear, and taken when the accumulator is non-zero. A jump spends a single fetch cycle, in which it issues either its target or the program counter. A stop operation freezes the core until the next reset. The core is meant for control sequencing where a tiny program in local memory is enough.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter and accumulator clear, the core goes to its fetch state and `mem_req` is low. The first access after release is a fetch at address 0x000.
- R2: A fetch cycle is a read (`mem_rnw` high) at the program counter, or at the jump target. The fetched word is latched as the next instruction, and the program counter becomes the issued address plus one, wrapping from 0xFFF to 0x000.
- R3: Operations 0 to 3 take exactly two memory cycles (operand access, then fetch). Operations 4 to 6 take exactly one. `mem_req` is high in every cycle between reset release and halt.
- R4: Operation 0 (load) reads address S and places the word in the accumulator.
- R5: Operation 1 (store) drives address S with `mem_rnw` low and `mem_wdata` equal to the accumulator. It is the only access that writes.
- R6: Operation 2 adds and operation 3 subtracts the word at S to or from the accumulator, modulo 2^16.
- R7: Operation 4 makes the next fetch use address S, and the program counter becomes S+1.
- R8: Operation 5 jumps to S only when accumulator bit 15 is 0. Otherwise the fetch continues at the program counter.
- R9: Operation 6 jumps to S only when the accumulator is not zero.
- R10: Operation 7, and every operation code from 8 to 15, stops the core. `halted` goes high in the cycle after the stop word is fetched, and from then on `mem_req` stays low and memory is never touched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address of the current access |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_req | output | 1 | An access is made this cycle |
| mem_rnw | output | 1 | High for a read, low for a write |
| halted | output | 1 | A stop operation has been reached |

## Verification
In a fetch cycle the core evaluates a conditional jump from the accumulator flags, and the same adder that feeds the program counter also has to produce the incremented target. When the previous instruction was a subtract, those flags were written by the execute cycle just before. The bench provokes this with a count-down loop in which a subtract that reaches zero is followed directly by a jump-if-non-zero, and with a load of 0x8000 followed by a jump-if-non-negative. A scoreboard compares every issued address, direction and write value with an instruction-level model, so a flag sampled one cycle late shows up as a wrong fetch address.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 4'd0,
      OP_STORE = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_JMP   = 4'd4,
      OP_JPOS  = 4'd5,
      OP_JNZ   = 4'd6,
      OP_HALT  = 4'd7
   } opcode_e;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'd0,
      ALU_SUB  = 2'd1,
      ALU_PASS = 2'd2,
      ALU_INC  = 2'd3
   } alu_sel_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  alu_sel_e     sel_i,
   input  logic         zero_i,
   output logic [W-1:0] y_o
);
   logic [W-1:0] a_g, b_g, sum;
   logic         cin;

   generate
      if (W < 2) begin : g_bad_width
         $error("acc_alu: width must be at least 2");
      end
   endgenerate

   always_comb begin
      a_g = (sel_i == ALU_PASS || sel_i == ALU_INC) ? '0 : a_i;
      b_g = (sel_i == ALU_SUB) ? ~b_i : b_i;
      cin = (sel_i == ALU_SUB) || (sel_i == ALU_INC);
      sum = a_g + b_g + {{(W-1){1'b0}}, cin};
      y_o = zero_i ? '0 : sum;
   end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_core_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] ir_op_i,
   input  logic [OPC_W-1:0] rd_op_i,
   input  logic             acc_zero_i,
   input  logic             acc_neg_i,
   output logic             ex_o,
   output logic             addr_ir_o,
   output logic             b_data_o,
   output alu_sel_e         alu_sel_o,
   output logic             zero_force_o,
   output logic             acc_en_o,
   output logic             pc_en_o,
   output logic             ir_en_o,
   output logic             req_o,
   output logic             rnw_o,
   output logic             halted_o
);
   logic ex_q, stop_in_ir, jump_taken, fetch_go, next_is_mem;

   always_comb begin
      stop_in_ir  = ir_op_i[OPC_W-1] || (ir_op_i == OP_HALT);
      next_is_mem = (rd_op_i[OPC_W-1:2] == '0);
      jump_taken  = (ir_op_i == OP_JMP)
                 || (ir_op_i == OP_JPOS && !acc_neg_i)
                 || (ir_op_i == OP_JNZ  && !acc_zero_i);
      halted_o     = rst_n && !ex_q && stop_in_ir;
      fetch_go     = rst_n && !ex_q && !stop_in_ir;
      zero_force_o = !rst_n;
      req_o        = rst_n && !halted_o;
      if (ex_q) begin
         addr_ir_o = 1'b1;
         b_data_o  = 1'b1;
         rnw_o     = (ir_op_i != OP_STORE);
         acc_en_o  = rst_n && (ir_op_i != OP_STORE);
         unique case (ir_op_i)
            OP_ADD:  alu_sel_o = ALU_ADD;
            OP_SUB:  alu_sel_o = ALU_SUB;
            default: alu_sel_o = ALU_PASS;
         endcase
      end else begin
         addr_ir_o = jump_taken;
         b_data_o  = 1'b0;
         rnw_o     = 1'b1;
         acc_en_o  = 1'b0;
         alu_sel_o = ALU_INC;
      end
      pc_en_o = !rst_n || fetch_go;
      ir_en_o = fetch_go;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ex_q <= 1'b0;
      else if (ex_q)     ex_q <= 1'b0;
      else if (fetch_go) ex_q <= next_is_mem;
   end

   assign ex_o = ex_q;

   assert_exec_then_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ex_q |=> !ex_q);
   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> (halted_o && !req_o));
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_req,
   output logic              mem_rnw,
   output logic              halted
);
   localparam int EXT_W = DATA_W - ADDR_W;

   generate
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_split
         $error("acc_core: DATA_W must equal opcode width plus ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q, acc_q, alu_b, alu_y;
   logic ex, addr_ir, b_data, zero_force, acc_en, pc_en, ir_en;
   alu_sel_e alu_sel;

   acc_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ir_op_i      (ir_q[DATA_W-1 -: OPC_W]),
      .rd_op_i      (mem_rdata[DATA_W-1 -: OPC_W]),
      .acc_zero_i   (acc_q == '0),
      .acc_neg_i    (acc_q[DATA_W-1]),
      .ex_o         (ex),
      .addr_ir_o    (addr_ir),
      .b_data_o     (b_data),
      .alu_sel_o    (alu_sel),
      .zero_force_o (zero_force),
      .acc_en_o     (acc_en),
      .pc_en_o      (pc_en),
      .ir_en_o      (ir_en),
      .req_o        (mem_req),
      .rnw_o        (mem_rnw),
      .halted_o     (halted)
   );

   assign mem_addr  = addr_ir ? ir_q[ADDR_W-1:0] : pc_q;
   assign mem_wdata = acc_q;
   assign alu_b     = b_data ? mem_rdata : {{EXT_W{1'b0}}, mem_addr};

   acc_alu #(.W(DATA_W)) u_alu (
      .a_i    (acc_q),
      .b_i    (alu_b),
      .sel_i  (alu_sel),
      .zero_i (zero_force),
      .y_o    (alu_y)
   );

   always_ff @(posedge clk) begin
      if (pc_en) pc_q <= alu_y[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ir_q <= '0;
      else if (ir_en) ir_q <= mem_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (acc_en) acc_q <= alu_y;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (pc_q == '0 && acc_q == '0 && !ex));
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !ex) |=> (pc_q == ADDR_W'($past(mem_addr) + 1'b1)));
   assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ex |=> $stable(acc_q));
   assert_write_in_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rnw) |-> ex);
   assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !ex && ir_q[DATA_W-1 -: OPC_W] == OP_JMP)
         |-> (mem_addr == ir_q[ADDR_W-1:0]));
endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
   localparam int CLK_P = 10;
   localparam int LIMIT = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic [15:0] mem_wdata;
   logic        mem_req, mem_rnw, halted;

   bit [15:0] mem  [int];
   bit [15:0] rmem [int];
   int    q_addr[$], q_rnw[$], q_wd[$];
   string q_tag[$];
   int nchk = 0, nerr = 0, cyc_cnt = 0;

   always #(CLK_P/2) clk = ~clk;

   acc_core dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_req(mem_req), .mem_rnw(mem_rnw), .halted(halted)
   );

   function automatic void chk(bit ok, string tag, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endfunction

   function automatic bit [15:0] ins(int op, int s);
      return 16'((op << 12) | (s & 12'hFFF));
   endfunction

   function automatic void push(int a, int rnw, int wd, string tag);
      q_addr.push_back(a); q_rnw.push_back(rnw); q_wd.push_back(wd); q_tag.push_back(tag);
   endfunction

   // Scoreboard monitor and memory model, sampled on the falling edge
   always @(negedge clk) begin
      mem_rdata <= '0;
      if (rst_n && mem_req) begin
         cyc_cnt++;
         if (q_addr.size() == 0) begin
            chk(0, "R10", "access after expected halt", int'(mem_addr), 0);
         end else begin
            int a, r, w;
            string t;
            a = q_addr.pop_front(); r = q_rnw.pop_front();
            w = q_wd.pop_front();   t = q_tag.pop_front();
            chk(int'(mem_addr) == a, t, "address", int'(mem_addr), a);
            chk(int'(mem_rnw) == r, t, "direction", int'(mem_rnw), r);
            if (r == 0) chk(int'(mem_wdata) == w, t, "write data", int'(mem_wdata), w);
         end
         if (mem_rnw) mem_rdata <= mem[int'(mem_addr)];
         else         mem[int'(mem_addr)] = mem_wdata;
      end
   end

   // Instruction-level model producing the expected access trace
   task automatic model();
      int pc, s;
      bit [15:0] acc, ir;
      string ft;
      pc = 0; acc = '0; ft = "R1";
      q_addr.delete(); q_rnw.delete(); q_wd.delete(); q_tag.delete();
      for (int st = 0; st < 1000; st++) begin
         ir = rmem[pc];
         push(pc, 1, 0, ft);
         ft = "R2";
         pc = (pc + 1) % 4096;
         s = int'(ir[11:0]);
         case (int'(ir[15:12]))
            0: begin push(s, 1, 0, "R4"); acc = rmem[s]; end
            1: begin push(s, 0, int'(acc), "R5"); rmem[s] = acc; end
            2: begin push(s, 1, 0, "R6"); acc = acc + rmem[s]; end
            3: begin push(s, 1, 0, "R6"); acc = acc - rmem[s]; end
            4: begin pc = s; ft = "R7"; end
            5: if (!acc[15]) begin pc = s; ft = "R8"; end
            6: if (acc != 0) begin pc = s; ft = "R9"; end
            default: return;
         endcase
      end
   endtask

   task automatic run_prog();
      int exp_n, n;
      rmem = mem;
      @(posedge clk); #1 rst_n = 1'b0;
      model();
      exp_n = q_addr.size();
      repeat (2) @(posedge clk);
      #1;
      chk(mem_req == 1'b0, "R1", "request during reset", int'(mem_req), 0);
      chk(halted == 1'b0, "R1", "halted during reset", int'(halted), 0);
      cyc_cnt = 0;
      rst_n = 1'b1;
      n = 0;
      while (!halted && n < LIMIT) begin
         @(posedge clk); #1 n++;
      end
      chk(n < LIMIT, "R10", "watchdog: no halt", n, LIMIT);
      chk(q_addr.size() == 0, "R3", "accesses left unmade", q_addr.size(), 0);
      chk(cyc_cnt == exp_n, "R3", "cycles to halt", cyc_cnt, exp_n);
      repeat (3) @(posedge clk);
      #1;
      chk(halted && !mem_req, "R10", "stays halted, no request", int'({halted, mem_req}), 2);
      foreach (rmem[k]) chk(mem[k] == rmem[k], "R5", $sformatf("memory word %0h", k),
                            int'(mem[k]), int'(rmem[k]));
   endtask

   task automatic load_loop();
      mem.delete();
      mem[0] = ins(0, 12'h020); mem[1] = ins(3, 12'h021); mem[2] = ins(1, 12'h020);
      mem[3] = ins(6, 1);       mem[4] = ins(1, 12'h022); mem[5] = ins(5, 7);
      mem[6] = ins(7, 0);       mem[7] = ins(0, 12'h023); mem[8] = ins(5, 10);
      mem[9] = ins(10, 0);      mem[10] = ins(7, 0);
      mem[12'h020] = 16'd3; mem[12'h021] = 16'd1; mem[12'h022] = 16'h5555;
      mem[12'h023] = 16'h8000;
   endtask

   initial begin
      #(CLK_P * 150000);
      nerr++;
      $display("FAIL R10 global watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      // Program 1: load, add with wrap, subtract, store
      mem.delete();
      mem[0] = ins(0, 12'h010); mem[1] = ins(2, 12'h011); mem[2] = ins(3, 12'h012);
      mem[3] = ins(1, 12'h013); mem[4] = ins(7, 0);
      mem[12'h010] = 16'h7FFF; mem[12'h011] = 16'h0002; mem[12'h012] = 16'h9000;
      run_prog();
      chk(mem[12'h013] == 16'hF001, "R6", "wrapped add then subtract", int'(mem[12'h013]), 'hF001);

      // Program 2: count-down loop, sign-clear jump, sign-set fallthrough, opcode 10 stop
      load_loop();
      run_prog();
      chk(mem[12'h020] == 16'h0000, "R9", "loop ran to zero", int'(mem[12'h020]), 0);
      chk(mem[12'h022] == 16'h0000, "R5", "store of zero", int'(mem[12'h022]), 0);

      // Program 3: program counter wrap from 0xFFF and reset-cleared accumulator
      mem.delete();
      mem[0] = ins(6, 12'h050); mem[1] = ins(4, 12'hFFF); mem[12'hFFF] = ins(0, 12'h030);
      mem[12'h030] = 16'd5; mem[12'h050] = ins(1, 12'h031); mem[12'h051] = ins(7, 0);
      run_prog();
      chk(mem[12'h031] == 16'd5, "R2", "value stored after address wrap", int'(mem[12'h031]), 5);

      // Program 4: reset in the middle of a run restarts at address 0
      load_loop();
      rmem = mem;
      model();
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (6) @(posedge clk);
      #1 rst_n = 1'b0;
      chk(mem_req == 1'b0, "R1", "request drops with reset", int'(mem_req), 0);
      load_loop();
      run_prog();

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule